// File: doc/BRIEF.md
# On-Board Memory Decoder With ROM Wait State

This block sits beside the processor on a single-board computer card and decides, every cycle, whether the current bus access targets the card's own memory. Two regions are decoded. The first is a 2 KB read-only region that is placed on any 2 KB boundary and split into two 1 KB devices. The second is a 1 KB read/write scratch region that is placed on any 1 KB boundary and can be shrunk to 512 or 256 bytes. Both placements come from boundary configuration inputs that are compared against the upper address bits.

The block also generates a memory-write strobe from the processor's status and write signals. It merges two external not-ready lines with an internal one-wait-state generator for on-board ROM reads into a single processor ready signal, which is sampled on clock-phase-2 enables. It turns off the card's external input data buffers while on-board memory drives the processor.

All decode outputs are registered: they reflect the inputs present at the previous rising clock edge.

Top module: `memdec_top`

## Requirements
- R1: `ram_cs` is 1 one clock after a cycle in which addr[15:10] equals `ram_base`, the RAM is enabled, the size check passes and a RAM read or write is present. It is 0 when the upper bits differ.
- R2: While a ROM access qualifies, `rom_cs[0]` is 1 when addr[15:11] equals `rom_base` and addr[10]=0, and `rom_cs[1]` is 1 when addr[10]=1. At most one bit is ever set.
- R3: A ROM select needs `st_memrd`=1 and `rd_strb`=1. It is suppressed while `rom_dis`=1 or `jump_busy`=1.
- R4: A RAM read needs `st_memrd`, `rd_strb` and a RAM match. A RAM write needs the memory-write strobe and a RAM match. `ram_we` is 1 only for writes.
- R5: The RAM is never selected while `ram_cfg_dis`=1 or `ram_ext_dis_n`=0.
- R6: `mem_wr` is 1 one clock after a cycle with `wr_n`=0 and `st_out`=0, and is 0 otherwise.
- R7: `cpu_rdy` changes only on clocks with `ph2_en`=1. At such a clock it becomes 0 if `ext_rdy_a`=0, `ext_rdy_b`=0 or a ROM wait is pending, and 1 otherwise.
- R8: A ROM wait is pending while a ROM access qualifies and no wait has yet been served in this machine cycle. The wait is served by the first `ph2_en` clock that samples it. `sync`=1 starts a new machine cycle, so back-to-back ROM reads each get exactly one wait.
- R9: `ram_size`=0 selects 1024 bytes, 1 selects 512 bytes (addr[9] must be 0), and 2 or 3 selects 256 bytes (addr[9:8] must be 0). Addresses above the chosen size are not selected.
- R10: `inbuf_dis` is 1 one clock after an on-board ROM read or RAM read. A RAM write alone does not raise it.
- R11: After reset, all chip selects, `ram_we`, `mem_wr` and `inbuf_dis` are 0 and `cpu_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address |
| st_memrd | input | 1 | Status: memory read cycle |
| st_out | input | 1 | Status: I/O output cycle |
| rd_strb | input | 1 | Read strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| sync | input | 1 | Start of machine cycle |
| ph2_en | input | 1 | Phase-2 sample enable |
| rom_base | input | 5 | ROM 2 KB boundary |
| ram_base | input | 6 | RAM 1 KB boundary |
| ram_size | input | 2 | RAM size select |
| rom_dis | input | 1 | ROM disable |
| jump_busy | input | 1 | Reset jump in progress, blocks ROM |
| ram_cfg_dis | input | 1 | RAM disable configuration bit |
| ram_ext_dis_n | input | 1 | External RAM disable, active low |
| ext_rdy_a | input | 1 | External ready A, low = not ready |
| ext_rdy_b | input | 1 | External ready B, low = not ready |
| rom_cs | output | 2 | ROM device selects |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| mem_wr | output | 1 | Memory-write strobe |
| cpu_rdy | output | 1 | Processor ready |
| inbuf_dis | output | 1 | External input buffer disable |

## Verification
The ROM wait generator and the external not-ready lines both drive `cpu_rdy`, and they can act on the same phase-2 sample. The bench holds `ext_rdy_a` low during a ROM read, so that the serving sample also sees an external hold. It then releases the external line while the ROM read continues and confirms that no second wait appears. It also places `sync` on the same clock as a phase-2 sample inside a ROM read, which checks that the cycle restart takes priority over marking the wait served. A reference model, written with integer arithmetic in the bench, predicts every output on every clock.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  typedef struct packed {
    logic ram_rd;
    logic ram_wr;
    logic rom_hit;
    logic memw;
  } memdec_hits_t;

  function automatic int unsigned clamp_shrink(input int unsigned req, input int unsigned max_s);
    return (req > max_s) ? max_s : req;
  endfunction
endpackage

// File: rtl/memdec_ram_dec.sv
module memdec_ram_dec #(
  parameter int ADDR_W     = 16,
  parameter int BLK_W      = 10,
  parameter int MAX_SHRINK = 2,
  localparam int TAG_W     = ADDR_W - BLK_W,
  localparam int SZ_W      = $clog2(MAX_SHRINK + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  base,
  input  logic [SZ_W-1:0]   size_sel,
  input  logic              enable,
  output logic              match
);
  import memdec_pkg::*;

  logic [MAX_SHRINK-1:0] bit_bad;
  int unsigned           shrink;

  assign shrink = clamp_shrink(int'(size_sel), MAX_SHRINK);

  for (genvar i = 0; i < MAX_SHRINK; i++) begin : g_size
    assign bit_bad[i] = (i < shrink) && addr[BLK_W-1-i];
  end

  assign match = enable && (addr[ADDR_W-1:BLK_W] == base) && !(|bit_bad);
endmodule

// File: rtl/memdec_rom_dec.sv
module memdec_rom_dec #(
  parameter int ADDR_W    = 16,
  parameter int BLK_W     = 11,
  parameter int DEV_W     = 10,
  localparam int TAG_W    = ADDR_W - BLK_W,
  localparam int NDEV     = 1 << (BLK_W - DEV_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  base,
  input  logic              enable,
  output logic              hit,
  output logic [NDEV-1:0]   dev_sel
);
  assign hit = enable && (addr[ADDR_W-1:BLK_W] == base);

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign dev_sel[d] = hit && (addr[BLK_W-1:DEV_W] == (BLK_W-DEV_W)'(d));
  end
endmodule

// File: rtl/memdec_wait.sv
module memdec_wait (
  input  logic clk,
  input  logic rst,
  input  logic ph2_en,
  input  logic sync,
  input  logic rom_hit,
  input  logic ext_rdy_a,
  input  logic ext_rdy_b,
  output logic cpu_rdy
);
  logic served_q;
  logic wait_req;
  logic rdy_q;

  assign wait_req = rom_hit && !served_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      served_q <= 1'b0;
      rdy_q    <= 1'b1;
    end else begin
      if (sync)
        served_q <= 1'b0;
      else if (ph2_en && wait_req)
        served_q <= 1'b1;
      if (ph2_en)
        rdy_q <= ext_rdy_a && ext_rdy_b && !wait_req;
    end
  end

  assign cpu_rdy = rdy_q;

  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ph2_en |=> $stable(cpu_rdy)); // R7
  AST_WAIT_SAMPLED: assert property (@(posedge clk) disable iff (rst)
    (ph2_en && wait_req) |=> !cpu_rdy); // R8
endmodule

// File: rtl/memdec_top.sv
module memdec_top #(
  parameter int ADDR_W      = 16,
  parameter int ROM_BLK_W   = 11,
  parameter int ROM_DEV_W   = 10,
  parameter int RAM_BLK_W   = 10,
  parameter int RAM_SHRINK  = 2,
  localparam int ROM_TAG_W  = ADDR_W - ROM_BLK_W,
  localparam int RAM_TAG_W  = ADDR_W - RAM_BLK_W,
  localparam int ROM_NDEV   = 1 << (ROM_BLK_W - ROM_DEV_W),
  localparam int SZ_W       = $clog2(RAM_SHRINK + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 st_memrd,
  input  logic                 st_out,
  input  logic                 rd_strb,
  input  logic                 wr_n,
  input  logic                 sync,
  input  logic                 ph2_en,
  input  logic [ROM_TAG_W-1:0] rom_base,
  input  logic [RAM_TAG_W-1:0] ram_base,
  input  logic [SZ_W-1:0]      ram_size,
  input  logic                 rom_dis,
  input  logic                 jump_busy,
  input  logic                 ram_cfg_dis,
  input  logic                 ram_ext_dis_n,
  input  logic                 ext_rdy_a,
  input  logic                 ext_rdy_b,
  output logic [ROM_NDEV-1:0]  rom_cs,
  output logic                 ram_cs,
  output logic                 ram_we,
  output logic                 mem_wr,
  output logic                 cpu_rdy,
  output logic                 inbuf_dis
);
  import memdec_pkg::*;

  memdec_hits_t       hits;
  logic               ram_match;
  logic               rom_en;
  logic               rom_hit;
  logic [ROM_NDEV-1:0] rom_dev;
  logic               rd_cycle;

  assign rd_cycle = st_memrd && rd_strb;
  assign rom_en   = rd_cycle && !rom_dis && !jump_busy;

  memdec_ram_dec #(
    .ADDR_W(ADDR_W), .BLK_W(RAM_BLK_W), .MAX_SHRINK(RAM_SHRINK)
  ) u_ram_dec (
    .addr(addr), .base(ram_base), .size_sel(ram_size),
    .enable(!ram_cfg_dis && ram_ext_dis_n), .match(ram_match)
  );

  memdec_rom_dec #(
    .ADDR_W(ADDR_W), .BLK_W(ROM_BLK_W), .DEV_W(ROM_DEV_W)
  ) u_rom_dec (
    .addr(addr), .base(rom_base), .enable(rom_en),
    .hit(rom_hit), .dev_sel(rom_dev)
  );

  always_comb begin
    hits.memw    = !wr_n && !st_out;
    hits.ram_rd  = ram_match && rd_cycle;
    hits.ram_wr  = ram_match && hits.memw;
    hits.rom_hit = rom_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs    <= '0;
      ram_cs    <= 1'b0;
      ram_we    <= 1'b0;
      mem_wr    <= 1'b0;
      inbuf_dis <= 1'b0;
    end else begin
      rom_cs    <= rom_dev;
      ram_cs    <= hits.ram_rd || hits.ram_wr;
      ram_we    <= hits.ram_wr;
      mem_wr    <= hits.memw;
      inbuf_dis <= hits.rom_hit || hits.ram_rd;
    end
  end

  memdec_wait u_wait (
    .clk(clk), .rst(rst), .ph2_en(ph2_en), .sync(sync),
    .rom_hit(rom_hit), .ext_rdy_a(ext_rdy_a), .ext_rdy_b(ext_rdy_b),
    .cpu_rdy(cpu_rdy)
  );

  AST_ROM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rom_cs)); // R2
  AST_ROM_GATED: assert property (@(posedge clk) disable iff (rst)
    (rom_dis || jump_busy || !rd_strb) |=> (rom_cs == '0)); // R3
  AST_WE_HAS_CS: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_cs); // R4
  AST_RAM_OFF: assert property (@(posedge clk) disable iff (rst)
    (ram_cfg_dis || !ram_ext_dis_n) |=> !ram_cs); // R5
  AST_MEMWR_IO: assert property (@(posedge clk) disable iff (rst)
    (st_out || wr_n) |=> !mem_wr); // R6
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph2_en && !(ext_rdy_a && ext_rdy_b)) |=> !cpu_rdy); // R7
  AST_ROM_BUFOFF: assert property (@(posedge clk) disable iff (rst)
    (|rom_cs) |-> inbuf_dis); // R10
endmodule

// File: tb/memdec_top_bench.sv
module memdec_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        st_memrd = 0, st_out = 0, rd_strb = 0, wr_n = 1, sync = 0, ph2_en = 0;
  logic [4:0]  rom_base = 5'h1E;
  logic [5:0]  ram_base = 6'h00;
  logic [1:0]  ram_size = 2'd0;
  logic        rom_dis = 0, jump_busy = 0, ram_cfg_dis = 0, ram_ext_dis_n = 1;
  logic        ext_rdy_a = 1, ext_rdy_b = 1;
  logic [1:0]  rom_cs;
  logic        ram_cs, ram_we, mem_wr, cpu_rdy, inbuf_dis;

  int tests = 0;
  int fails = 0;
  string prev_tag = "R11";

  // reference model state
  logic [1:0] e_rom;
  logic       e_ramcs, e_we, e_mw, e_rdy, e_buf, m_served;

  always #5 clk = ~clk;

  memdec_top u_memdec_top (
    .clk(clk), .rst(rst), .addr(addr), .st_memrd(st_memrd), .st_out(st_out),
    .rd_strb(rd_strb), .wr_n(wr_n), .sync(sync), .ph2_en(ph2_en),
    .rom_base(rom_base), .ram_base(ram_base), .ram_size(ram_size),
    .rom_dis(rom_dis), .jump_busy(jump_busy), .ram_cfg_dis(ram_cfg_dis),
    .ram_ext_dis_n(ram_ext_dis_n), .ext_rdy_a(ext_rdy_a), .ext_rdy_b(ext_rdy_b),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we), .mem_wr(mem_wr),
    .cpu_rdy(cpu_rdy), .inbuf_dis(inbuf_dis)
  );

  always @(posedge clk) begin
    int  a, lim, sz;
    bit  rd, memw, ramhit, romhit, wreq;
    a    = int'(addr);
    rd   = st_memrd && rd_strb;
    memw = !wr_n && !st_out;
    sz   = (ram_size > 2) ? 2 : int'(ram_size);
    lim  = 1024 >> sz;
    ramhit = !ram_cfg_dis && ram_ext_dis_n && ((a / 1024) == int'(ram_base)) && ((a % 1024) < lim);
    romhit = rd && !rom_dis && !jump_busy && ((a / 2048) == int'(rom_base));
    wreq   = romhit && !m_served;
    if (rst) begin
      e_rom <= 2'b00; e_ramcs <= 0; e_we <= 0; e_mw <= 0; e_buf <= 0;
      e_rdy <= 1; m_served <= 0;
    end else begin
      e_rom   <= romhit ? (((a / 1024) % 2 == 1) ? 2'b10 : 2'b01) : 2'b00;
      e_ramcs <= ramhit && (rd || memw);
      e_we    <= ramhit && memw;
      e_mw    <= memw;
      e_buf   <= romhit || (ramhit && rd);
      if (sync) m_served <= 0;
      else if (ph2_en && wreq) m_served <= 1;
      if (ph2_en) e_rdy <= ext_rdy_a && ext_rdy_b && !wreq;
    end
  end

  task automatic cmp(input string tag, input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) act=%0d exp=%0d", rq, tag, act, exp);
    end
  endtask

  task automatic check_all();
    cmp(prev_tag, "R2 rom_cs",   int'(rom_cs),    int'(e_rom));
    cmp(prev_tag, "R1 ram_cs",   int'(ram_cs),    int'(e_ramcs));
    cmp(prev_tag, "R4 ram_we",   int'(ram_we),    int'(e_we));
    cmp(prev_tag, "R6 mem_wr",   int'(mem_wr),    int'(e_mw));
    cmp(prev_tag, "R7 cpu_rdy",  int'(cpu_rdy),   int'(e_rdy));
    cmp(prev_tag, "R10 inbuf",   int'(inbuf_dis), int'(e_buf));
  endtask

  task automatic step(input string tag, input logic [15:0] a, input logic mr,
                      input logic rd, input logic wn, input logic o, input logic sy);
    @(negedge clk);
    check_all();
    addr = a; st_memrd = mr; rd_strb = rd; wr_n = wn; st_out = o; sync = sy;
    ph2_en = ~ph2_en;
    prev_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(tag, 16'h0000, 0, 0, 1, 0, 0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset values
    @(negedge clk);
    cmp("R11", "R11 rom_cs", int'(rom_cs), 0);
    cmp("R11", "R11 cpu_rdy", int'(cpu_rdy), 1);
    cmp("R11", "R11 inbuf", int'(inbuf_dis), 0);
    idle("R11");
    // R1 / R10: RAM read hit and miss
    step("R1_hit",  16'h0010, 1, 1, 1, 0, 1);
    step("R1_top",  16'h03FF, 1, 1, 1, 0, 0);
    step("R1_miss", 16'h0400, 1, 1, 1, 0, 1);
    ram_base = 6'h3F;
    step("R1_high", 16'hFC20, 1, 1, 1, 0, 1);
    ram_base = 6'h00;
    // R4 / R6 / R10: RAM write, write during I/O output
    step("R4_wr",   16'h0100, 0, 0, 0, 0, 1);
    step("R6_io",   16'h0100, 0, 0, 0, 1, 1);
    step("R4_rdonly", 16'h0100, 1, 0, 1, 0, 1);
    step("R6_wr_far", 16'h8000, 0, 0, 0, 0, 1);
    // R5: RAM disables
    ram_cfg_dis = 1;
    step("R5_cfg",  16'h0010, 1, 1, 1, 0, 1);
    step("R5_cfgw", 16'h0010, 0, 0, 0, 0, 1);
    ram_cfg_dis = 0; ram_ext_dis_n = 0;
    step("R5_ext",  16'h0010, 1, 1, 1, 0, 1);
    ram_ext_dis_n = 1;
    // R9: size options
    ram_size = 2'd1;
    step("R9_512in",  16'h01FF, 1, 1, 1, 0, 1);
    step("R9_512out", 16'h0200, 1, 1, 1, 0, 1);
    ram_size = 2'd2;
    step("R9_256in",  16'h00FF, 1, 1, 1, 0, 1);
    step("R9_256out", 16'h0100, 0, 0, 0, 0, 1);
    ram_size = 2'd3;
    step("R9_sz3",    16'h0300, 1, 1, 1, 0, 1);
    ram_size = 2'd0;
    idle("R9");
    // R2 / R8: ROM device 0 read, full machine cycle
    step("R8_sync", 16'hF000, 0, 0, 1, 0, 1);
    for (int i = 0; i < 4; i++) step("R2_dev0", 16'hF000, 1, 1, 1, 0, 0);
    // back-to-back ROM read of device 1
    step("R8_b2b",  16'hF7FF, 1, 1, 1, 0, 1);
    for (int i = 0; i < 4; i++) step("R2_dev1", 16'hF7FF, 1, 1, 1, 0, 0);
    step("R2_miss", 16'hF800, 1, 1, 1, 0, 1);
    step("R2_miss", 16'hE7FF, 1, 1, 1, 0, 0);
    // R3: gating
    rom_dis = 1;
    step("R3_dis",  16'hF000, 1, 1, 1, 0, 1);
    step("R3_dis",  16'hF000, 1, 1, 1, 0, 0);
    rom_dis = 0; jump_busy = 1;
    step("R3_jump", 16'hF400, 1, 1, 1, 0, 1);
    step("R3_jump", 16'hF400, 1, 1, 1, 0, 0);
    jump_busy = 0;
    step("R3_nostrb", 16'hF400, 1, 0, 1, 0, 1);
    step("R3_nostat", 16'hF400, 0, 1, 1, 0, 0);
    // R7 with R8 in the same sample: external hold during ROM read
    ext_rdy_a = 0;
    step("R7_both", 16'hF400, 1, 1, 1, 0, 1);
    step("R7_both", 16'hF400, 1, 1, 1, 0, 0);
    step("R7_both", 16'hF400, 1, 1, 1, 0, 0);
    ext_rdy_a = 1;
    for (int i = 0; i < 3; i++) step("R8_nosecond", 16'hF400, 1, 1, 1, 0, 0);
    ext_rdy_b = 0;
    step("R7_extb", 16'h8000, 0, 0, 1, 0, 1);
    step("R7_extb", 16'h8000, 0, 0, 1, 0, 0);
    step("R7_extb", 16'h8000, 0, 0, 1, 0, 0);
    ext_rdy_b = 1;
    step("R7_rel",  16'h8000, 0, 0, 1, 0, 0);
    step("R7_rel",  16'h8000, 0, 0, 1, 0, 0);
    // R8: sync on a phase-2 clock inside a ROM read
    for (int i = 0; i < 6; i++) step("R8_syncph2", 16'hF000, 1, 1, 1, 0, (i % 2 == 1));
    // R10: overlapping ROM and RAM regions both read
    ram_base = 6'h3C;
    step("R10_overlap", 16'hF000, 1, 1, 1, 0, 1);
    ram_base = 6'h00;
    idle("R10");
    idle("R11_end");
    @(negedge clk);
    check_all();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule